// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and walks the memory through its mandatory start-up procedure after a synchronous reset. It drives the clock-enable, the command pins (chip select, row strobe, column strobe, write enable), the bank-select and the address pins. When the procedure is over it raises a done flag that stays high until the next reset.

The procedure runs in a fixed order:

1. Clock-enable is held low for a settling time given in nanoseconds. It is converted to clock cycles from a clock-period parameter.
2. Clock-enable goes high together with an idle (no-operation) command.
3. All banks are closed.
4. The extended mode register is written to switch the delay-locked loop on.
5. The mode register is written with the loop-reset bit set.
6. A lock time of at least 200 cycles is counted.
7. All banks are closed again.
8. A programmable number of refreshes is issued, at least two.
9. The mode register is written a second time with the loop-reset bit clear. This write carries the burst length, the burst order and the read latency.

Between any two commands the sequencer drives the idle encoding. Each command is followed by its own parameterised recovery gap before the next one.

The controller holds its normal command path off until the done flag rises. It then takes over the same pins.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and after it: clock-enable is 0, the command pins show idle, address and bank are 0, and done is 0. After reset falls, clock-enable stays 0 for STABLE_CYC = ceil(STABLE_NS*1000/CLK_PERIOD_PS) cycles, plus one cycle when REG_OUT=1.
- R2: Clock-enable rises in a cycle that carries the idle command, and never falls again until reset. While clock-enable is 0, the row, column and write strobes are all high.
- R3: Commands appear in this order: close-all, extended-mode write, mode write with loop reset, close-all, REFRESH_CNT refreshes, final mode write. A reset in the middle restarts the order from the settling wait.
- R4: Pin encodings as {cs_n,ras_n,cas_n,we_n}: idle 0111, close-all 0010, mode/extended-mode write 0000, refresh 0001. Close-all drives addr[10]=1 and every other address bit and the bank to 0.
- R5: The extended-mode write drives bank=01 and addr[0]=0 (loop enabled). It drives addr[1]=DRIVE_HALF and all other address bits 0.
- R6: Both mode writes drive bank=00 with these fields: addr[2:0]=MODE_BL, addr[3]=MODE_BT, addr[6:4]=MODE_CL. addr[8] is 1 in the first write and 0 in the final one, and all other bits are 0.
- R7: Spacing between command issue cycles is exact. From the clock-enable idle to the first close-all: CKE_NOP_CYC. After a close-all: TRP_CYC. After the extended-mode write: TMRD_CYC. After a refresh: TRFC_CYC.
- R8: The next command follows the mode write with loop reset after exactly DLL_LOCK_CYC cycles, where DLL_LOCK_CYC is at least 200.
- R9: Once clock-enable is high, chip select is 0 on every cycle. Every cycle without a command carries the idle encoding.
- R10: Done rises exactly TMRD_CYC cycles after the final mode write and stays high until reset. No further command is issued while it is high.
- R11: Exactly REFRESH_CNT refresh commands are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Memory clock-enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select, also picks the mode register |
| addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | High once start-up is complete |

## Verification
The assertions assume that reset is synchronous and held across at least one rising edge. They also assume that the parameters satisfy the elaboration checks: gaps of at least two cycles, a lock time of at least 200 cycles, and at least two refreshes. Their spacing counters saturate, so they make no claim about gaps beyond that range.

The bench changes reset only just after a rising edge. It keeps reset high for several cycles and uses parameter values inside those limits. It asserts reset once during the lock wait, to show that the sequence restarts from the settling wait.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [3:0] {
      ST_STABLE,
      ST_CKE_UP,
      ST_PRE_A,
      ST_EMRS,
      ST_MRS_RST,
      ST_PRE_B,
      ST_REFRESH,
      ST_MRS_RUN,
      ST_DONE
   } step_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

   localparam pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam pins_t PINS_LOAD = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
   localparam pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= RST_VAL;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_step_fsm.sv
module ddr_init_step_fsm
   import ddr_init_pkg::*;
#(
   parameter int W            = 8,
   parameter int CKE_NOP_CYC  = 2,
   parameter int TRP_CYC      = 3,
   parameter int TRFC_CYC     = 7,
   parameter int TMRD_CYC     = 2,
   parameter int DLL_LOCK_CYC = 200,
   parameter int REFRESH_CNT  = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tzero,
   output step_e        step,
   output logic         issuing,
   output logic         tload,
   output logic [W-1:0] tval
);

   localparam int RW = $clog2(REFRESH_CNT + 1);

   step_e         step_q, step_d;
   logic          issue_q, issue_d;
   logic [RW-1:0] ref_q, ref_d;

   function automatic logic [W-1:0] gap_of(input step_e s);
      case (s)
         ST_CKE_UP:  return W'(CKE_NOP_CYC - 2);
         ST_PRE_A,
         ST_PRE_B:   return W'(TRP_CYC - 2);
         ST_EMRS,
         ST_MRS_RUN: return W'(TMRD_CYC - 2);
         ST_MRS_RST: return W'(DLL_LOCK_CYC - 2);
         ST_REFRESH: return W'(TRFC_CYC - 2);
         default:    return '0;
      endcase
   endfunction

   always_comb begin
      step_d  = step_q;
      issue_d = issue_q;
      ref_d   = ref_q;
      tload   = 1'b0;
      tval    = '0;
      if (issue_q) begin
         tload   = 1'b1;
         tval    = gap_of(step_q);
         issue_d = 1'b0;
         if (step_q == ST_REFRESH) begin
            ref_d = ref_q + 1'b1;
         end
      end else if (step_q != ST_DONE && tzero) begin
         issue_d = 1'b1;
         case (step_q)
            ST_STABLE:  step_d = ST_CKE_UP;
            ST_CKE_UP:  step_d = ST_PRE_A;
            ST_PRE_A:   step_d = ST_EMRS;
            ST_EMRS:    step_d = ST_MRS_RST;
            ST_MRS_RST: step_d = ST_PRE_B;
            ST_PRE_B:   step_d = ST_REFRESH;
            ST_REFRESH: step_d = (ref_q == RW'(REFRESH_CNT)) ? ST_MRS_RUN : ST_REFRESH;
            ST_MRS_RUN: begin
               step_d  = ST_DONE;
               issue_d = 1'b0;
            end
            default: begin
               step_d  = ST_DONE;
               issue_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q  <= ST_STABLE;
         issue_q <= 1'b0;
         ref_q   <= '0;
      end else begin
         step_q  <= step_d;
         issue_q <= issue_d;
         ref_q   <= ref_d;
      end
   end

   assign step    = step_q;
   assign issuing = issue_q;

endmodule

// File: rtl/ddr_init_pin_enc.sv
module ddr_init_pin_enc
   import ddr_init_pkg::*;
#(
   parameter int         ADDR_W     = 12,
   parameter int         BA_W       = 2,
   parameter bit         REG_OUT    = 1'b1,
   parameter logic [2:0] MODE_BL    = 3'b011,
   parameter logic       MODE_BT    = 1'b0,
   parameter logic [2:0] MODE_CL    = 3'b011,
   parameter logic       DRIVE_HALF = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  step_e             step,
   input  logic              issuing,
   output logic              cke,
   output pins_t             pins,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);

   pins_t             c_pins;
   logic [BA_W-1:0]   c_ba;
   logic [ADDR_W-1:0] c_addr;
   logic              c_cke;
   logic              c_done;

   function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
      logic [ADDR_W-1:0] w;
      w      = '0;
      w[2:0] = MODE_BL;
      w[3]   = MODE_BT;
      w[6:4] = MODE_CL;
      w[8]   = dll_rst;
      return w;
   endfunction

   always_comb begin
      c_pins = PINS_NOP;
      c_ba   = '0;
      c_addr = '0;
      c_cke  = (step != ST_STABLE);
      c_done = (step == ST_DONE);
      if (issuing) begin
         case (step)
            ST_PRE_A, ST_PRE_B: begin
               c_pins     = PINS_PRE;
               c_addr[10] = 1'b1;
            end
            ST_EMRS: begin
               c_pins    = PINS_LOAD;
               c_ba      = BA_W'(1);
               c_addr[0] = 1'b0;
               c_addr[1] = DRIVE_HALF;
            end
            ST_MRS_RST: begin
               c_pins = PINS_LOAD;
               c_addr = mode_word(1'b1);
            end
            ST_MRS_RUN: begin
               c_pins = PINS_LOAD;
               c_addr = mode_word(1'b0);
            end
            ST_REFRESH: c_pins = PINS_REF;
            default:    c_pins = PINS_NOP;
         endcase
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            pins <= PINS_NOP;
            ba   <= '0;
            addr <= '0;
            cke  <= 1'b0;
            done <= 1'b0;
         end else begin
            pins <= c_pins;
            ba   <= c_ba;
            addr <= c_addr;
            cke  <= c_cke;
            done <= c_done;
         end
      end
   end else begin : g_comb
      assign pins = c_pins;
      assign ba   = c_ba;
      assign addr = c_addr;
      assign cke  = c_cke;
      assign done = c_done;
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int         CLK_PERIOD_PS = 10000,
   parameter int         STABLE_NS     = 200000,
   parameter int         CKE_NOP_CYC   = 2,
   parameter int         TRP_CYC       = 3,
   parameter int         TRFC_CYC      = 7,
   parameter int         TMRD_CYC      = 2,
   parameter int         DLL_LOCK_CYC  = 200,
   parameter int         REFRESH_CNT   = 2,
   parameter int         ADDR_W        = 12,
   parameter int         BA_W          = 2,
   parameter bit         REG_OUT       = 1'b1,
   parameter logic [2:0] MODE_BL       = 3'b011,
   parameter logic       MODE_BT       = 1'b0,
   parameter logic [2:0] MODE_CL       = 3'b011,
   parameter logic       DRIVE_HALF    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int STABLE_CYC = (STABLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int CNT_MAX    = max_of(max_of(STABLE_CYC, DLL_LOCK_CYC),
                                      max_of(max_of(TRP_CYC, TRFC_CYC),
                                             max_of(TMRD_CYC, CKE_NOP_CYC)));
   localparam int W          = $clog2(CNT_MAX + 1);

   if (STABLE_NS < 200000) begin : g_bad_stable
      $error("settling wait shorter than 200 us");
   end
   if (DLL_LOCK_CYC < 200) begin : g_bad_lock
      $error("lock wait shorter than 200 cycles");
   end
   if (REFRESH_CNT < 2) begin : g_bad_ref
      $error("at least two refreshes are required");
   end
   if (CKE_NOP_CYC < 2 || TRP_CYC < 2 || TRFC_CYC < 2 || TMRD_CYC < 2) begin : g_bad_gap
      $error("command gaps must be at least two cycles");
   end
   if (ADDR_W < 11 || BA_W < 2 || CLK_PERIOD_PS < 1) begin : g_bad_width
      $error("address or bank width too small");
   end

   step_e        step;
   logic         issuing;
   logic         tload;
   logic [W-1:0] tval;
   logic         tzero;
   pins_t        pins;

   ddr_init_timer #(
      .W       (W),
      .RST_VAL (W'(STABLE_CYC - 1))
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tload),
      .load_val (tval),
      .zero     (tzero)
   );

   ddr_init_step_fsm #(
      .W            (W),
      .CKE_NOP_CYC  (CKE_NOP_CYC),
      .TRP_CYC      (TRP_CYC),
      .TRFC_CYC     (TRFC_CYC),
      .TMRD_CYC     (TMRD_CYC),
      .DLL_LOCK_CYC (DLL_LOCK_CYC),
      .REFRESH_CNT  (REFRESH_CNT)
   ) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .tzero   (tzero),
      .step    (step),
      .issuing (issuing),
      .tload   (tload),
      .tval    (tval)
   );

   ddr_init_pin_enc #(
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W),
      .REG_OUT    (REG_OUT),
      .MODE_BL    (MODE_BL),
      .MODE_BT    (MODE_BT),
      .MODE_CL    (MODE_CL),
      .DRIVE_HALF (DRIVE_HALF)
   ) u_enc (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .issuing (issuing),
      .cke     (cke),
      .pins    (pins),
      .ba      (ba),
      .addr    (addr),
      .done    (init_done)
   );

   assign cs_n  = pins.cs_n;
   assign ras_n = pins.ras_n;
   assign cas_n = pins.cas_n;
   assign we_n  = pins.we_n;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
   parameter int TRP_CYC      = 3,
   parameter int TRFC_CYC     = 7,
   parameter int DLL_LOCK_CYC = 200,
   parameter int BA_W         = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            cke,
   input logic            cs_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic [BA_W-1:1] ba_hi,
   input logic            ba_lo,
   input logic            a10,
   input logic            a8,
   input logic            init_done
);

   typedef enum logic [1:0] {K_NONE, K_PRE, K_REF, K_DLL} kind_e;

   logic [2:0]  rcw;
   logic        is_cmd;
   logic [15:0] since_q;
   kind_e       kind_q;

   assign rcw    = {ras_n, cas_n, we_n};
   assign is_cmd = !cs_n && (rcw != 3'b111);

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
         kind_q  <= K_NONE;
      end else if (is_cmd) begin
         since_q <= 16'd1;
         if (rcw == 3'b010)
            kind_q <= K_PRE;
         else if (rcw == 3'b001)
            kind_q <= K_REF;
         else if (rcw == 3'b000 && a8 && !ba_lo)
            kind_q <= K_DLL;
         else
            kind_q <= K_NONE;
      end else if (since_q != 16'hFFFF) begin
         since_q <= since_q + 16'd1;
      end
   end

   // R9
   cs_low_chk: assert property (@(posedge clk) disable iff (rst) cke |-> !cs_n);
   // R2
   cke_hold_chk: assert property (@(posedge clk) disable iff (rst) cke |=> cke);
   // R2
   cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst) !cke |-> (rcw == 3'b111));
   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done);
   // R10
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst) init_done |-> !is_cmd);
   // R7
   trp_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && kind_q == K_PRE) |-> (since_q >= 16'(TRP_CYC)));
   // R7
   trfc_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && kind_q == K_REF) |-> (since_q >= 16'(TRFC_CYC)));
   // R8
   dll_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && kind_q == K_DLL) |-> (since_q >= 16'(DLL_LOCK_CYC)));
   // R6
   load_bank_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && rcw == 3'b000) |-> (ba_hi == '0));
   // R4
   pre_all_chk: assert property (@(posedge clk) disable iff (rst)
      (is_cmd && rcw == 3'b010) |-> a10);

endmodule

bind ddr_init_seq ddr_init_chk #(
   .TRP_CYC      (TRP_CYC),
   .TRFC_CYC     (TRFC_CYC),
   .DLL_LOCK_CYC (DLL_LOCK_CYC),
   .BA_W         (BA_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba_hi     (ba[BA_W-1:1]),
   .ba_lo     (ba[0]),
   .a10       (addr[10]),
   .a8        (addr[8]),
   .init_done (init_done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

   localparam int         PERIOD_PS  = 10000;
   localparam int         STABLE_NS  = 200000;
   localparam int         CKE_NOP    = 2;
   localparam int         TRP        = 3;
   localparam int         TRFC       = 7;
   localparam int         TMRD       = 2;
   localparam int         DLL        = 200;
   localparam int         NREF       = 3;
   localparam bit         REG        = 1'b1;
   localparam logic [2:0] BL         = 3'b010;
   localparam logic       BT         = 1'b1;
   localparam logic [2:0] CL         = 3'b010;
   localparam logic       DRV        = 1'b1;
   localparam int         STABLE_CYC = (STABLE_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
   localparam int         EXP_LOW    = STABLE_CYC + (REG ? 1 : 0);

   localparam logic [3:0] P_NOP  = 4'b0111;
   localparam logic [3:0] P_PRE  = 4'b0010;
   localparam logic [3:0] P_LOAD = 4'b0000;
   localparam logic [3:0] P_REF  = 4'b0001;

   typedef struct {
      logic [3:0]  pins;
      logic [1:0]  ba;
      logic [11:0] addr;
      int          gap;
      string       enc_tag;
      string       gap_tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [1:0]  ba;
   logic [11:0] addr;

   item_t exp_q[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   int    cyc = 0, lowcnt = 0, last_cyc = 0, n_cmds = 0;
   int    nop_bad = 0, cke_drop = 0, done_drop = 0, extra = 0;
   bit    seen_high = 0, done_seen = 0, finished = 0;

   always #5 clk = ~clk;

   ddr_init_seq #(
      .CLK_PERIOD_PS (PERIOD_PS),
      .STABLE_NS     (STABLE_NS),
      .CKE_NOP_CYC   (CKE_NOP),
      .TRP_CYC       (TRP),
      .TRFC_CYC      (TRFC),
      .TMRD_CYC      (TMRD),
      .DLL_LOCK_CYC  (DLL),
      .REFRESH_CNT   (NREF),
      .ADDR_W        (12),
      .BA_W          (2),
      .REG_OUT       (REG),
      .MODE_BL       (BL),
      .MODE_BT       (BT),
      .MODE_CL       (CL),
      .DRIVE_HALF    (DRV)
   ) u_dut (
      .clk       (clk),
      .rst       (rst),
      .cke       (cke),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .addr      (addr),
      .init_done (init_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [11:0] mode_word(input logic dll_rst);
      logic [11:0] w;
      w      = '0;
      w[2:0] = BL;
      w[3]   = BT;
      w[6:4] = CL;
      w[8]   = dll_rst;
      return w;
   endfunction

   task automatic push(input logic [3:0] p, input logic [1:0] b, input logic [11:0] a,
                       input int g, input string et, input string gt);
      item_t it;
      it.pins = p; it.ba = b; it.addr = a; it.gap = g;
      it.enc_tag = et; it.gap_tag = gt;
      exp_q.push_back(it);
   endtask

   task automatic load_expected();
      exp_q.delete();
      push(P_PRE,  2'b00, 12'h400,               CKE_NOP, "R3 R4", "R7");
      push(P_LOAD, 2'b01, {10'd0, DRV, 1'b0},    TRP,     "R3 R5", "R7");
      push(P_LOAD, 2'b00, mode_word(1'b1),       TMRD,    "R3 R6", "R7");
      push(P_PRE,  2'b00, 12'h400,               DLL,     "R3 R4", "R8");
      for (int i = 0; i < NREF; i++)
         push(P_REF, 2'b00, 12'h000, (i == 0) ? TRP : TRFC, "R11 R4", "R7");
      push(P_LOAD, 2'b00, mode_word(1'b0),       TRFC,    "R3 R6", "R7");
   endtask

   task automatic check_reset_state();
      check(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
      check({cs_n, ras_n, cas_n, we_n} == P_NOP, "R1", "pins in reset",
            int'({cs_n, ras_n, cas_n, we_n}), int'(P_NOP));
      check(init_done == 1'b0, "R1", "done in reset", int'(init_done), 0);
      check(addr == '0 && ba == '0, "R1", "addr/ba in reset", int'({ba, addr}), 0);
   endtask

   // monitor: pops expected commands and compares
   always @(negedge clk) begin
      logic [3:0] p;
      item_t      it;
      if (rst) begin
         cyc = 0; lowcnt = 0; seen_high = 0; done_seen = 0; n_cmds = 0;
      end else begin
         cyc++;
         p = {cs_n, ras_n, cas_n, we_n};
         if (!seen_high) begin
            if (!cke) lowcnt++;
            else begin
               seen_high = 1;
               check(lowcnt == EXP_LOW, "R1", "cke low cycles", lowcnt, EXP_LOW);
               check(p == P_NOP, "R2", "pins at cke rise", int'(p), int'(P_NOP));
               last_cyc = cyc;
            end
         end else begin
            if (!cke) cke_drop++;
            if (cs_n) nop_bad++;
            if (!cs_n && p != P_NOP) begin
               if (exp_q.size() == 0) extra++;
               else begin
                  it = exp_q.pop_front();
                  check(p == it.pins, it.enc_tag, "command pins", int'(p), int'(it.pins));
                  check(ba == it.ba, it.enc_tag, "bank", int'(ba), int'(it.ba));
                  check(addr == it.addr, it.enc_tag, "address", int'(addr), int'(it.addr));
                  check(cyc - last_cyc == it.gap, it.gap_tag, "spacing", cyc - last_cyc, it.gap);
               end
               last_cyc = cyc;
               n_cmds++;
            end
            if (init_done && !done_seen) begin
               done_seen = 1;
               check(exp_q.size() == 0, "R11", "commands left at done", exp_q.size(), 0);
               check(cyc - last_cyc == TMRD, "R10", "done delay", cyc - last_cyc, TMRD);
            end else if (done_seen && !init_done) begin
               done_drop++;
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected init_done");
         summary();
         $finish;
      end
   end

   initial begin
      int guard;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check_reset_state();
      load_expected();
      @(posedge clk); #1 rst = 1'b0;

      // run into the lock wait, then reset in the middle (R3)
      repeat (STABLE_CYC + 100) @(posedge clk);
      @(negedge clk);
      check(n_cmds == 3, "R3", "commands before mid reset", n_cmds, 3);
      check(cke == 1'b1, "R2", "cke during lock wait", int'(cke), 1);
      check(init_done == 1'b0, "R10", "done before finish", int'(init_done), 0);
      @(posedge clk); #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state();
      load_expected();
      @(posedge clk); #1 rst = 1'b0;

      guard = 0;
      while (!init_done && guard < 60000) begin
         @(posedge clk);
         guard++;
      end
      repeat (60) @(posedge clk);
      @(negedge clk);
      check(done_seen == 1'b1, "R10", "done raised", int'(done_seen), 1);
      check(init_done == 1'b1, "R10", "done still high", int'(init_done), 1);
      check(done_drop == 0, "R10", "done drops", done_drop, 0);
      check(extra == 0, "R10", "commands after sequence", extra, 0);
      check(exp_q.size() == 0, "R3", "missing commands", exp_q.size(), 0);
      check(n_cmds == 5 + NREF, "R11", "command count", n_cmds, 5 + NREF);
      check(nop_bad == 0, "R9", "cycles with cs_n high", nop_bad, 0);
      check(cke_drop == 0, "R2", "cke drops", cke_drop, 0);
      finished = 1;
      summary();
      $finish;
   end

endmodule